// File: doc/BRIEF.md
# Double-Precision Rounding Stage

This block is the final stage of a double-precision floating-point datapath. An arithmetic unit upstream delivers a result that has not yet been rounded: a sign, a biased exponent, and a significand. The significand carries the integer bit, the 52 fraction bits and three extra low-order bits (guard, round, sticky). The block applies one of four rounding modes and produces the final 64-bit encoding. It also raises the inexact, overflow and underflow status flags.

Rounding can carry out of the significand. When that happens the block renormalizes. A normal value whose fraction is all ones moves up one binade. A subnormal value whose fraction is all ones becomes the smallest normal value. The input exponent is one bit wider than the output field, so an upstream result that has already overflowed can be passed in and is mapped to the correct overflow value. The result is registered with one cycle of latency and comes with a valid flag.

Top module: `fp_round_unit`

## Requirements
- R1: The output word places the sign at bit 63, the 11-bit biased exponent at bits 62:52 and the fraction at bits 51:0. In `in_sig`, bit 55 is the integer bit, bits 54:3 are the fraction, and bits 2, 1 and 0 are guard, round and sticky. When those three bits are zero and no overflow occurs, the exponent and fraction pass through unchanged and the sign is always kept.
- R2: With `rmode` = 00 (nearest), the value is incremented when guard is 1 and either round, sticky or the fraction LSB is 1. An exact tie therefore rounds to an even fraction.
- R3: With `rmode` = 01 (toward zero), the value is never incremented. If the input exponent is below 2047, the output exponent field never reaches 2047.
- R4: With `rmode` = 10 (toward +inf), only positive inexact values are incremented. With `rmode` = 11 (toward -inf), only negative inexact values are incremented.
- R5: If incrementing a normal value carries out of the significand, the exponent rises by one and the fraction becomes zero.
- R6: If incrementing a subnormal value (exponent 0) carries into the integer bit, the output has exponent field 1 and fraction zero.
- R7: Overflow occurs when the exponent after rounding is 2047 or more. The result is then infinity (exponent 2047, fraction 0) for mode 00, for mode 10 with a positive sign, and for mode 11 with a negative sign. For every other combination the result is the largest finite value (exponent 2046, fraction all ones) of the same sign.
- R8: `out_inexact` is 1 when any of guard, round or sticky is nonzero, or when overflow occurs.
- R9: `out_underflow` is 1 exactly when the delivered exponent field is 0 and the result is inexact.
- R10: Output word and flags register the input one clock edge after `in_valid`. `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, the word and flags hold their values.
- R11: A synchronous active-high `rst` clears `out_valid`, the word and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input result present this cycle |
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | 12 | Biased exponent; 0 means subnormal, 2047 or more means overflowed |
| in_sig | input | 56 | Integer bit, fraction, guard, round, sticky |
| rmode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Output word and flags updated |
| out_word | output | 64 | Rounded double-precision encoding |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
Three situations are hard to bring about because they need an exact bit pattern. The first is a carry that ripples through all 53 significand bits. The second is that carry happening at the top of the exponent range, where it must turn into overflow. The third is the carry from the largest subnormal into the normal range, where the underflow flag must stay low even though the input was tiny. The stimulus table builds each case from an all-ones fraction with guard set and the matching exponent (1023, 2046 and 0). It pairs each with a neighbour that must not round up, such as the same pattern in mode toward zero or an exact subnormal. Directed steps after the table check the hold behaviour while `in_valid` is low, and a reset that arrives together with a valid input.

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sign,
  input  logic [EW:0]      in_exp,
  input  logic [FW+3:0]    in_sig,
  input  logic [1:0]       rmode,
  output logic             out_valid,
  output logic [EW+FW:0]   out_word,
  output logic             out_overflow,
  output logic             out_underflow,
  output logic             out_inexact
);
  localparam int SW = FW + 4;
  localparam int XW = EW + 2;
  localparam logic [XW-1:0] EINF = XW'((1 << EW) - 1);

  logic          lsb, lost, inc, to_inf, ovf, unf;
  logic [FW+1:0] sum;
  logic [XW-1:0] exp_r;
  logic [EW+FW:0] result;

  assign lsb  = in_sig[3];
  assign lost = |in_sig[2:0];

  always_comb begin
    case (rmode)
      2'b00:   inc = in_sig[2] & (in_sig[1] | in_sig[0] | lsb);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~in_sign & lost;
      default: inc = in_sign & lost;
    endcase
  end

  assign sum   = {1'b0, in_sig[SW-1:3]} + (FW+2)'(inc);
  assign exp_r = {1'b0, in_exp} + XW'(sum[FW+1] | ((in_exp == '0) & sum[FW]));
  assign ovf   = exp_r >= EINF;
  assign to_inf = (rmode == 2'b00) | ((rmode == 2'b10) & ~in_sign) | ((rmode == 2'b11) & in_sign);
  assign unf   = ~ovf & (exp_r == '0) & lost;

  always_comb begin
    if (!ovf)
      result = {in_sign, exp_r[EW-1:0], sum[FW-1:0]};
    else if (to_inf)
      result = {in_sign, {EW{1'b1}}, {FW{1'b0}}};
    else
      result = {in_sign, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_word      <= '0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
      out_inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word      <= result;
        out_overflow  <= ovf;
        out_underflow <= unf;
        out_inexact   <= lost | ovf;
      end
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_no_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_word)));
  assert_sign_kept_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[EW+FW] == $past(in_sign));
  assert_rz_no_inf_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rmode == 2'b01 && in_exp < (EW+1)'((1 << EW) - 1)) |=> out_word[EW+FW-1:FW] != {EW{1'b1}});
  assert_ovf_code_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_overflow) |-> out_word[EW+FW-1:FW+1] == {(EW-1){1'b1}});
  assert_ovf_inexact_R8: assert property (@(posedge clk) disable iff (rst)
    out_overflow |-> out_inexact);
  assert_unf_tiny_R9: assert property (@(posedge clk) disable iff (rst)
    out_underflow |-> (out_word[EW+FW-1:FW] == '0 && out_inexact));
endmodule

// File: tb/fp_round_unit_tb.sv
module fp_round_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 22;
  localparam logic [51:0] F1 = 52'hFFFFFFFFFFFFF;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_sign = 1'b0;
  logic [11:0] in_exp = '0;
  logic [55:0] in_sig = '0;
  logic [1:0]  rmode = '0;
  logic        out_valid, out_overflow, out_underflow, out_inexact;
  logic [63:0] out_word;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_round_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .rmode(rmode),
    .out_valid(out_valid), .out_word(out_word), .out_overflow(out_overflow),
    .out_underflow(out_underflow), .out_inexact(out_inexact));

  // {sign, exp12, hidden, frac52, grs3, mode2, expected word, {ovf,unf,inx}}
  localparam logic [137:0] VEC [N] = '{
    {1'b0, 12'd1023, 1'b1, 52'h0, 3'b000, 2'b00, 64'h3FF0000000000000, 3'b000},
    {1'b0, 12'd1023, 1'b1, 52'h0, 3'b100, 2'b00, 64'h3FF0000000000000, 3'b001},
    {1'b0, 12'd1023, 1'b1, 52'h1, 3'b100, 2'b00, 64'h3FF0000000000002, 3'b001},
    {1'b0, 12'd1023, 1'b1, 52'h0, 3'b101, 2'b00, 64'h3FF0000000000001, 3'b001},
    {1'b0, 12'd1023, 1'b1, 52'h0, 3'b011, 2'b00, 64'h3FF0000000000000, 3'b001},
    {1'b0, 12'd1023, 1'b1, 52'h0, 3'b111, 2'b01, 64'h3FF0000000000000, 3'b001},
    {1'b0, 12'd1023, 1'b1, 52'h0, 3'b001, 2'b10, 64'h3FF0000000000001, 3'b001},
    {1'b1, 12'd1023, 1'b1, 52'h0, 3'b001, 2'b10, 64'hBFF0000000000000, 3'b001},
    {1'b1, 12'd1023, 1'b1, 52'h0, 3'b001, 2'b11, 64'hBFF0000000000001, 3'b001},
    {1'b0, 12'd1023, 1'b1, 52'h0, 3'b001, 2'b11, 64'h3FF0000000000000, 3'b001},
    {1'b0, 12'd1023, 1'b1, F1,    3'b100, 2'b00, 64'h4000000000000000, 3'b001},
    {1'b0, 12'd0,    1'b0, F1,    3'b110, 2'b00, 64'h0010000000000000, 3'b001},
    {1'b0, 12'd0,    1'b0, 52'h1, 3'b100, 2'b00, 64'h0000000000000002, 3'b011},
    {1'b0, 12'd0,    1'b0, 52'h5, 3'b000, 2'b00, 64'h0000000000000005, 3'b000},
    {1'b0, 12'd2046, 1'b1, F1,    3'b100, 2'b00, 64'h7FF0000000000000, 3'b101},
    {1'b0, 12'd2047, 1'b1, 52'h0, 3'b000, 2'b01, 64'h7FEFFFFFFFFFFFFF, 3'b101},
    {1'b1, 12'd2050, 1'b1, 52'h0, 3'b000, 2'b10, 64'hFFEFFFFFFFFFFFFF, 3'b101},
    {1'b1, 12'd2047, 1'b1, 52'h0, 3'b000, 2'b11, 64'hFFF0000000000000, 3'b101},
    {1'b0, 12'd2047, 1'b1, 52'h0, 3'b000, 2'b10, 64'h7FF0000000000000, 3'b101},
    {1'b1, 12'd0,    1'b0, 52'h0, 3'b000, 2'b00, 64'h8000000000000000, 3'b000},
    {1'b0, 12'd0,    1'b0, 52'h0, 3'b011, 2'b00, 64'h0000000000000000, 3'b011},
    {1'b0, 12'd2046, 1'b1, F1,    3'b000, 2'b01, 64'h7FEFFFFFFFFFFFFF, 3'b000}
  };
  localparam string TAG [N] = '{
    "R1", "R2", "R2", "R2", "R2", "R3", "R4", "R4", "R4", "R4", "R5",
    "R6", "R9", "R9", "R7", "R7", "R7", "R7", "R7", "R1", "R8", "R3"
  };

  task automatic check(input string tag, input logic [63:0] aw, input logic [3:0] af,
                       input logic [63:0] ew, input logic [3:0] ef);
    checks++;
    if (aw !== ew || af !== ef) begin
      fails++;
      $display("FAIL %s: word=%h flags(v,o,u,i)=%b expected word=%h flags=%b", tag, aw, af, ew, ef);
    end
  endtask

  function automatic logic [3:0] flags();
    return {out_valid, out_overflow, out_underflow, out_inexact};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] last_word;
    repeat (3) @(negedge clk);
    check("R11 reset", out_word, flags(), 64'h0, 4'b0000);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      in_valid = 1'b1;
      {in_sign, in_exp, in_sig, rmode} = VEC[i][137:67];
      @(negedge clk);
      check(TAG[i], out_word, flags(), VEC[i][66:3], {1'b1, VEC[i][2:0]});
    end
    last_word = VEC[N-1][66:3];
    // R10: idle input must not disturb registered result
    in_valid = 1'b0;
    {in_sign, in_exp, in_sig, rmode} = VEC[0][137:67];
    @(negedge clk);
    check("R10 hold", out_word, flags(), last_word, 4'b0000);
    @(negedge clk);
    check("R10 hold2", out_word, flags(), last_word, 4'b0000);
    // R10: a single valid after a gap appears one cycle later
    in_valid = 1'b1;
    {in_sign, in_exp, in_sig, rmode} = VEC[14][137:67];
    @(negedge clk);
    check("R10 latency", out_word, flags(), 64'h7FF0000000000000, 4'b1101);
    // R11: reset wins over a valid input
    rst = 1'b1;
    {in_sign, in_exp, in_sig, rmode} = VEC[2][137:67];
    @(negedge clk);
    check("R11 reset with valid", out_word, flags(), 64'h0, 4'b0000);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule